// File: doc/BRIEF.md
# Sampled Input Noise Canceler

This block sits between a capture-timer input pin and the timer's edge detector. It removes short glitches from the pin. The pin is first brought into the clock domain by a synchronizer. The synchronized level is then sampled at a programmable rate into a short shift chain. The filtered level moves to a new value only when every tap of the chain holds that value. A pulse that does not last long enough to fill the chain therefore never reaches the timer.

A prescaler makes the sampling rate. It counts system-clock cycles and issues a one-cycle strobe at one of four selectable ratios. An enable input picks between the filtered level and the unfiltered pin. A run input stops the whole filter without losing its state, which models module standby. The block has no data stream, so every port is a plain level with no handshake. `rate_sel`, `filt_en` and `mod_run` may change in any cycle and take effect at the next clock edge.

Top module: `pin_deglitch_filter`

## Requirements
- R1: A clock edge with `rst` high clears the five taps, the filtered level and the prescaler count to 0. With `filt_en` high, `filt_out` reads 0 after reset.
- R2: The level sampled into the chain is `pin_raw` delayed by exactly two clock edges, through a two-flop synchronizer.
- R3: `rate_sel` codes 00, 01, 10 and 11 select sampling ratios of 2, 8, 32 and 64 clock cycles. The prescaler count rises by one in each running cycle. The strobe fires in a cycle where the count is at or above ratio−1, and the count then returns to 0.
- R4: On each strobe the chain shifts by one tap, and the newest synchronized sample enters tap 0.
- R5: The filtered level becomes 1 at the clock edge after all five taps hold 1. It becomes 0 at the clock edge after all five taps hold 0. Otherwise it keeps its value.
- R6: With the filter enabled and the pin settled, a pulse lasting at most four sample periods (4×ratio cycles) never changes `filt_out`.
- R7: With `filt_en` low, `filt_out` equals `pin_raw` in the same cycle. The chain keeps sampling meanwhile.
- R8: `mod_run` at 0 means standby and 1 means running. In standby the prescaler count, the taps and the filtered level are frozen, so with the filter enabled `filt_out` holds.
- R9: At a fixed rate and while running, a new pin level held steady appears on `filt_out` at no fewer than 4×ratio+3 and no more than 5×ratio+2 clock edges after the first edge that registers it. In any case it appears within 5×64+4 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 1 | Unfiltered capture-pin level |
| filt_en | input | 1 | 1 selects the filtered level, 0 passes the pin straight through |
| rate_sel | input | 2 | Sampling ratio code (00:2, 01:8, 10:32, 11:64) |
| mod_run | input | 1 | 1 runs the filter, 0 holds it in standby |
| filt_out | output | 1 | Level delivered to the capture edge detector |

## Verification
Two events can land on the same clock edge: a prescaler strobe, and a standby entry or a change of sampling ratio. Both decide whether the chain shifts on that edge. The bench toggles `mod_run` and `rate_sel` at random cycle offsets, so these changes fall on, just before and just after strobe edges across many runs. A cycle-exact model built from R2 to R5 and R8 judges every cycle. A freeze property confirms that no tap moves in a standby cycle.

// File: rtl/ndf_pkg.sv
package ndf_pkg;

  typedef enum logic [1:0] {
    RATE_FINE   = 2'b00,
    RATE_MID    = 2'b01,
    RATE_SLOW   = 2'b10,
    RATE_SLOWER = 2'b11
  } rate_e;

  // Maps a select code onto one of four divide ratios.
  function automatic int unsigned pick_div(input logic [1:0] code,
                                           input int unsigned d0,
                                           input int unsigned d1,
                                           input int unsigned d2,
                                           input int unsigned d3);
    case (rate_e'(code))
      RATE_FINE: return d0;
      RATE_MID:  return d1;
      RATE_SLOW: return d2;
      default:   return d3;
    endcase
  endfunction

endpackage

// File: rtl/ndf_prescaler.sv
module ndf_prescaler
  import ndf_pkg::*;
#(
  parameter int unsigned DIV_0 = 2,
  parameter int unsigned DIV_1 = 8,
  parameter int unsigned DIV_2 = 32,
  parameter int unsigned DIV_3 = 64   // largest ratio, sizes the counter
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  localparam int unsigned CW = $clog2(DIV_3 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb lim = CW'(pick_div(rate_sel, DIV_0, DIV_1, DIV_2, DIV_3) - 1);

  // ">=" keeps a ratio change mid-count from overrunning the wrap point.
  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (run) cnt_q <= tick ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/ndf_sync.sv
module ndf_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[DEPTH-2:0], d};
  end

  assign q = pipe_q[DEPTH-1];
endmodule

// File: rtl/ndf_match_chain.sv
module ndf_match_chain #(
  parameter int unsigned TAPS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            din,
  output logic [TAPS-1:0] taps,
  output logic            lvl
);
  logic all_hi;
  logic all_lo;

  always_ff @(posedge clk) begin
    if (rst)       taps <= '0;
    else if (tick) taps <= {taps[TAPS-2:0], din};
  end

  assign all_hi = &taps;
  assign all_lo = ~|taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b0;
    end else if (run) begin
      if (all_hi)      lvl <= 1'b1;
      else if (all_lo) lvl <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_deglitch_filter.sv
module pin_deglitch_filter #(
  parameter int unsigned DIV_R0     = 2,
  parameter int unsigned DIV_R1     = 8,
  parameter int unsigned DIV_R2     = 32,
  parameter int unsigned DIV_R3     = 64,
  parameter int unsigned SYNC_DEPTH = 2,
  parameter int unsigned TAPS       = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic       filt_en,
  input  logic [1:0] rate_sel,
  input  logic       mod_run,
  output logic       filt_out
);
  logic            pin_sync;
  logic            smp_tick;
  logic [TAPS-1:0] tap_vec;
  logic            flt_lvl;

  ndf_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_sync)
  );

  ndf_prescaler #(
    .DIV_0(DIV_R0), .DIV_1(DIV_R1), .DIV_2(DIV_R2), .DIV_3(DIV_R3)
  ) u_presc (
    .clk      (clk),
    .rst      (rst),
    .run      (mod_run),
    .rate_sel (rate_sel),
    .tick     (smp_tick)
  );

  ndf_match_chain #(.TAPS(TAPS)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .run  (mod_run),
    .tick (smp_tick),
    .din  (pin_sync),
    .taps (tap_vec),
    .lvl  (flt_lvl)
  );

  // Bypass passes the pin unregistered; the chain keeps running behind it.
  assign filt_out = filt_en ? flt_lvl : pin_raw;
endmodule

// File: rtl/ndf_checker.sv
module ndf_checker #(
  parameter int unsigned TAPS       = 5,
  parameter int unsigned DIV_MAX    = 64,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            pin_raw,
  input logic            mod_run,
  input logic            strobe,
  input logic            sync_lvl,
  input logic [TAPS-1:0] taps,
  input logic            lvl
);
  localparam int unsigned LAT = SYNC_DEPTH + TAPS * DIV_MAX + 2;
  localparam int unsigned QW  = $clog2(LAT + 2);

  logic [QW-1:0] quiet_q;
  logic          pin_prev_q;
  logic [1:0]    warm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q    <= '0;
      pin_prev_q <= 1'b0;
      warm_q     <= '0;
    end else begin
      pin_prev_q <= pin_raw;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      if (!mod_run || (pin_raw != pin_prev_q)) quiet_q <= '0;
      else if (quiet_q != QW'(LAT))            quiet_q <= quiet_q + QW'(1);
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (lvl == 1'b0 && taps == '0));

  // R2: valid once enough edges have passed since reset
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3) |-> (sync_lvl == $past(pin_raw, SYNC_DEPTH)));

  // R4
  a_r4_shift_on_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (taps[0] == $past(sync_lvl) &&
                taps[TAPS-1:1] == $past(taps[TAPS-2:0])));

  // R5
  a_r5_change_needs_match: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl) |-> ($past(taps) == {TAPS{lvl}}));

  // R8
  a_r8_standby_freeze: assert property (@(posedge clk) disable iff (rst)
    !mod_run |=> ($stable(taps) && $stable(lvl)));

  // R9: window tracked by a counter, not a long delay
  a_r9_settle_bound: assert property (@(posedge clk) disable iff (rst)
    (quiet_q == QW'(LAT)) |-> (lvl == pin_prev_q));
endmodule

bind pin_deglitch_filter ndf_checker #(
  .TAPS(TAPS), .DIV_MAX(DIV_R3), .SYNC_DEPTH(SYNC_DEPTH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pin_raw  (pin_raw),
  .mod_run  (mod_run),
  .strobe   (smp_tick),
  .sync_lvl (pin_sync),
  .taps     (tap_vec),
  .lvl      (flt_lvl)
);

// File: tb/tb_pin_deglitch_filter.sv
`timescale 1ns/1ps
module tb_pin_deglitch_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0;
  logic       filt_en = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic       mod_run = 1'b1;
  logic       filt_out;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pin_deglitch_filter dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .filt_en(filt_en),
    .rate_sel(rate_sel), .mod_run(mod_run), .filt_out(filt_out)
  );

  function automatic int div_of(input logic [1:0] c);
    case (c)
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 32;
      default: return 64;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-exact expectation taken from R2, R3, R4, R5, R8
  logic       m_s1, m_s2, m_f;
  logic [4:0] m_stg;
  int         m_cnt;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_f <= 0; m_stg <= '0; m_cnt <= 0;
    end else begin
      m_s1 <= pin_raw;
      m_s2 <= m_s1;
      if (mod_run) begin
        if (m_cnt >= div_of(rate_sel) - 1) begin
          m_cnt <= 0;
          m_stg <= {m_stg[3:0], m_s2};
        end else begin
          m_cnt <= m_cnt + 1;
        end
        if (m_stg == 5'h1f)      m_f <= 1'b1;
        else if (m_stg == 5'h00) m_f <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      logic exp_v;
      exp_v = filt_en ? m_f : pin_raw;
      check(filt_out === exp_v, "R2 R3 R4 R5 R7 model", int'(filt_out), int'(exp_v));
    end
  end

  task automatic drive(input logic p, input logic e, input logic [1:0] r, input logic run);
    @(posedge clk); #1;
    pin_raw = p; filt_en = e; rate_sel = r; mod_run = run;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    #1 rst = 1'b0;
    @(negedge clk);
    check(filt_out === 1'b0, "R1 reset level", int'(filt_out), 0);
    cmp_on = 1'b1;

    // R7: bypass follows the pin in the same cycle
    drive(1, 0, 2'b00, 1);
    @(negedge clk);
    check(filt_out === 1'b1, "R7 bypass high", int'(filt_out), 1);
    drive(0, 0, 2'b00, 1);
    @(negedge clk);
    check(filt_out === 1'b0, "R7 bypass low", int'(filt_out), 0);

    // R6: 8-cycle pulse at ratio 2 spans at most four samples
    drive(0, 1, 2'b00, 1);
    idle(40);
    drive(1, 1, 2'b00, 1);
    begin
      bit seen = 0;
      for (int i = 0; i < 7; i++) begin @(negedge clk); if (filt_out) seen = 1; end
      drive(0, 1, 2'b00, 1);
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (filt_out) seen = 1; end
      check(!seen, "R6 short pulse rejected", int'(seen), 0);
    end

    // R5: a long pulse gets through
    drive(1, 1, 2'b00, 1);
    idle(30);
    @(negedge clk);
    check(filt_out === 1'b1, "R5 long pulse passes", int'(filt_out), 1);

    // R8: standby holds the output even though the pin drops
    drive(0, 1, 2'b00, 0);
    idle(200);
    @(negedge clk);
    check(filt_out === 1'b1, "R8 standby hold", int'(filt_out), 1);
    drive(0, 1, 2'b00, 1);
    idle(20);
    @(negedge clk);
    check(filt_out === 1'b0, "R8 resume follows pin", int'(filt_out), 0);

    // R3 / R9: latency window for each ratio code
    for (int c = 0; c < 4; c++) begin
      int d = div_of(2'(c));
      int lat = 0;
      drive(0, 1, 2'(c), 1);
      idle(6 * d + 10);
      drive(1, 1, 2'(c), 1);
      while (filt_out !== 1'b1 && lat < 8 * d + 20) begin
        @(negedge clk);
        lat++;
      end
      check(lat >= 4 * d + 5 && lat <= 5 * d + 4, "R3 R9 latency", lat, 5 * d + 4);
    end

    // Random mix; the model judges each cycle, including strobe/standby overlaps
    for (int s = 0; s < 260; s++) begin
      logic       p = 1'($urandom % 2);
      logic       e = filt_en;
      logic [1:0] r = rate_sel;
      logic       run = mod_run;
      int         hold;
      if ($urandom % 8 == 0)  r = 2'($urandom % 4);
      if ($urandom % 10 == 0) e = ~e;
      if ($urandom % 6 == 0)  run = ~run;
      if (!run && ($urandom % 2 == 0)) run = 1'b1;
      hold = ($urandom % 4 == 0) ? 1 + int'($urandom % 6) : 1 + int'($urandom % 300);
      drive(p, e, r, run);
      idle(hold);
    end

    // R1: reset mid-run clears the filtered level
    drive(1, 1, 2'b00, 1);
    idle(30);
    #1 rst = 1'b1;
    idle(2);
    #1 rst = 1'b0;
    @(negedge clk);
    check(filt_out === 1'b0, "R1 reset after high", int'(filt_out), 0);
    idle(5);

    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule